// File: doc/BRIEF.md
# Virtual-8086 Sensitive Instruction Arbiter

This block rules on every flag, interrupt or port instruction that a processor meets while it runs 8086 code inside protected mode. A decoder presents an instruction class in one cycle, together with the privilege field that governs interrupt-flag access (IOPL), the virtual-interrupt enable control, the current real and virtual interrupt flags, the pending-virtual-interrupt flag, the vector number of a software interrupt and a 256-entry redirection map. One cycle later the block reports an action code, the resulting real and virtual interrupt flags and a 16-bit flag image.

There are three privilege situations. When IOPL is 3 the code is trusted with the real interrupt flag. When IOPL is below 3 and virtual interrupts are off, every sensitive instruction faults. When IOPL is below 3 and virtual interrupts are on, flag instructions act on the virtual flag, and a pending virtual interrupt turns any attempt to set that flag into a fault. The pending flag is read and never written. A two-state machine controls the output: ST_IDLE, and ST_EMIT, which holds the result for one cycle. The transition T_ACCEPT goes from either state to ST_EMIT when a request is present. T_DRAIN goes from ST_EMIT to ST_IDLE when no request is present. T_WAIT holds ST_IDLE while no request arrives.

Top module: `v86_arb`

## Requirements
- R1: While reset is high and in the cycle after it falls, res_valid is 0 and res_action, res_vif, res_if and res_image are all 0.
- R2: Each cycle with req_valid high produces res_valid high in exactly the following cycle, so back-to-back requests give back-to-back pulses. Without a request the other outputs keep their last value. req_op codes are CLI=0, STI=1, PUSHF=2, POPF=3, INT n=4, IRET=5, port I/O=6, HLT=7. res_action codes are native=0, fault=1, redirect=2, protected-mode trap=3.
- R3: HLT (req_op 7) always gives action 1, and the flags are unchanged.
- R4: Port I/O (req_op 6) always gives action 0 for every IOPL and VME value.
- R5: With iopl<3 and vme=0, req_op 0 to 5 give action 1, and res_if and res_vif equal their inputs.
- R6: With iopl=3, CLI clears res_if, STI sets it, and POPF copies bit 9 of pop_flags into it. PUSHF and IRET change nothing. All of these give action 0 and leave res_vif equal to cur_vif.
- R7: With iopl=3, INT n gives action 3.
- R8: With iopl<3 and vme=1, CLI clears res_vif and STI sets it (when cur_vip=0), with action 0 and res_if equal to cur_if.
- R9: res_image is cur_flags with bit 9 replaced by cur_vif when iopl<3 and vme=1, and equal to cur_flags otherwise. This applies to every op except POPF.
- R10: With iopl<3 and vme=1, POPF sets res_vif to pop_flags bit 9 and leaves res_if equal to cur_if. For POPF, res_image is pop_flags with bit 9 replaced by the resulting res_if.
- R11: With iopl<3, vme=1 and cur_vip=1, STI, and POPF with pop_flags bit 9 set, give action 1 with res_vif equal to cur_vif. POPF with bit 9 clear is not blocked.
- R12: With iopl<3 and vme=1, INT n gives action 2 if redir_map[vec] is 1 and action 1 otherwise.
- R13: With iopl<3 and vme=1, IRET gives action 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A decoded instruction is present |
| req_op | input | 3 | Instruction class |
| iopl | input | 2 | I/O privilege field |
| vme | input | 1 | Virtual-interrupt extensions enable |
| cur_if | input | 1 | Current real interrupt flag |
| cur_vif | input | 1 | Current virtual interrupt flag |
| cur_vip | input | 1 | Virtual interrupt pending flag |
| vec | input | 8 | Software interrupt vector |
| redir_map | input | 256 | One redirection bit per vector |
| cur_flags | input | 16 | Current flag register image |
| pop_flags | input | 16 | Image popped by POPF |
| res_valid | output | 1 | One-cycle result strobe |
| res_action | output | 2 | Action code |
| res_if | output | 1 | Resulting real interrupt flag |
| res_vif | output | 1 | Resulting virtual interrupt flag |
| res_image | output | 16 | Flag image stored or loaded |

## Verification
Two functions can fall on the same instruction: the pending-interrupt check and the virtual-flag update, when STI or POPF tries to set the virtual flag while cur_vip is 1. A second pair is the delivery of one result and the acceptance of the next request, which meet in a single cycle. The bench drives long back-to-back bursts in which cur_vip, the popped bit 9 and cur_vif change on every request. Its reference model then predicts the fault, whether the virtual flag is held and the pulse for each request. It compares all outputs with those predictions on every clock.

// File: rtl/v86_arb_pkg.sv
package v86_arb_pkg;
    typedef enum logic [2:0] {
        OP_CLI    = 3'd0,
        OP_STI    = 3'd1,
        OP_PUSHF  = 3'd2,
        OP_POPF   = 3'd3,
        OP_INTN   = 3'd4,
        OP_IRET   = 3'd5,
        OP_PORTIO = 3'd6,
        OP_HLT    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ACT_NATIVE = 2'd0,
        ACT_GPF    = 2'd1,
        ACT_REDIR  = 2'd2,
        ACT_TRAP   = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        PM_DIRECT = 2'd0,
        PM_VIRT   = 2'd1,
        PM_STRICT = 2'd2
    } pmode_e;

    typedef struct packed {
        act_e act;
        logic vif;
        logic intf;
    } verdict_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } arb_state_e;
endpackage

// File: rtl/v86_mode_sel.sv
module v86_mode_sel
    import v86_arb_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic [PRIV_W-1:0] iopl,
    input  logic              vme,
    output pmode_e            pmode
);
    localparam logic [PRIV_W-1:0] TOP_PRIV = '1;

    always_comb begin
        if (iopl == TOP_PRIV)
            pmode = PM_DIRECT;
        else if (vme)
            pmode = PM_VIRT;
        else
            pmode = PM_STRICT;
    end
endmodule

// File: rtl/v86_verdict.sv
module v86_verdict
    import v86_arb_pkg::*;
(
    input  op_e      op,
    input  pmode_e   pmode,
    input  logic     cur_if,
    input  logic     cur_vif,
    input  logic     cur_vip,
    input  logic     pop_if,
    input  logic     redir_bit,
    output verdict_t verdict
);
    always_comb begin
        verdict.act  = ACT_NATIVE;
        verdict.vif  = cur_vif;
        verdict.intf = cur_if;
        unique case (op)
            OP_HLT:    verdict.act = ACT_GPF;
            OP_PORTIO: verdict.act = ACT_NATIVE;
            default: begin
                unique case (pmode)
                    PM_STRICT: verdict.act = ACT_GPF;
                    PM_DIRECT: begin
                        unique case (op)
                            OP_CLI:  verdict.intf = 1'b0;
                            OP_STI:  verdict.intf = 1'b1;
                            OP_POPF: verdict.intf = pop_if;
                            OP_INTN: verdict.act  = ACT_TRAP;
                            default: verdict.act  = ACT_NATIVE;
                        endcase
                    end
                    PM_VIRT: begin
                        unique case (op)
                            OP_CLI: verdict.vif = 1'b0;
                            OP_STI: begin
                                if (cur_vip) verdict.act = ACT_GPF;
                                else         verdict.vif = 1'b1;
                            end
                            OP_POPF: begin
                                if (pop_if && cur_vip) verdict.act = ACT_GPF;
                                else                   verdict.vif = pop_if;
                            end
                            OP_INTN: verdict.act = redir_bit ? ACT_REDIR : ACT_GPF;
                            OP_IRET: verdict.act = ACT_GPF;
                            default: verdict.act = ACT_NATIVE;
                        endcase
                    end
                    default: verdict.act = ACT_GPF;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/v86_image.sv
module v86_image
    import v86_arb_pkg::*;
#(
    parameter int FLAG_W = 16,
    parameter int IF_POS = 9
) (
    input  op_e               op,
    input  pmode_e            pmode,
    input  logic [FLAG_W-1:0] cur_flags,
    input  logic [FLAG_W-1:0] pop_flags,
    input  logic              cur_vif,
    input  logic              new_if,
    output logic [FLAG_W-1:0] image
);
    always_comb begin
        if (op == OP_POPF) begin
            image         = pop_flags;
            image[IF_POS] = new_if;
        end else begin
            image = cur_flags;
            if (pmode == PM_VIRT)
                image[IF_POS] = cur_vif;
        end
    end
endmodule

// File: rtl/v86_arb.sv
module v86_arb
    import v86_arb_pkg::*;
#(
    parameter int PRIV_W = 2,
    parameter int VEC_W  = 8,
    parameter int FLAG_W = 16,
    parameter int IF_POS = 9,
    localparam int MAP_W = 1 << VEC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [PRIV_W-1:0] iopl,
    input  logic              vme,
    input  logic              cur_if,
    input  logic              cur_vif,
    input  logic              cur_vip,
    input  logic [VEC_W-1:0]  vec,
    input  logic [MAP_W-1:0]  redir_map,
    input  logic [FLAG_W-1:0] cur_flags,
    input  logic [FLAG_W-1:0] pop_flags,
    output logic              res_valid,
    output logic [1:0]        res_action,
    output logic              res_if,
    output logic              res_vif,
    output logic [FLAG_W-1:0] res_image
);
    op_e               op;
    pmode_e            pmode;
    verdict_t          verdict;
    logic [FLAG_W-1:0] image;
    arb_state_e        state_q, state_d;

    assign op = op_e'(req_op);

    v86_mode_sel #(.PRIV_W(PRIV_W)) u_mode (
        .iopl  (iopl),
        .vme   (vme),
        .pmode (pmode)
    );

    v86_verdict u_verdict (
        .op        (op),
        .pmode     (pmode),
        .cur_if    (cur_if),
        .cur_vif   (cur_vif),
        .cur_vip   (cur_vip),
        .pop_if    (pop_flags[IF_POS]),
        .redir_bit (redir_map[vec]),
        .verdict   (verdict)
    );

    v86_image #(.FLAG_W(FLAG_W), .IF_POS(IF_POS)) u_image (
        .op        (op),
        .pmode     (pmode),
        .cur_flags (cur_flags),
        .pop_flags (pop_flags),
        .cur_vif   (cur_vif),
        .new_if    (verdict.intf),
        .image     (image)
    );

    // T_ACCEPT / T_DRAIN / T_WAIT
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_action <= 2'd0;
            res_if     <= 1'b0;
            res_vif    <= 1'b0;
            res_image  <= '0;
        end else if (req_valid) begin
            res_action <= verdict.act;
            res_if     <= verdict.intf;
            res_vif    <= verdict.vif;
            res_image  <= image;
        end
    end

    assign res_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/v86_arb_chk.sv
module v86_arb_chk #(
    parameter int PRIV_W = 2,
    parameter int VEC_W  = 8,
    parameter int FLAG_W = 16,
    localparam int MAP_W = 1 << VEC_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [PRIV_W-1:0] iopl,
    input logic              vme,
    input logic              cur_if,
    input logic              cur_vif,
    input logic              cur_vip,
    input logic [VEC_W-1:0]  vec,
    input logic [MAP_W-1:0]  redir_map,
    input logic              res_valid,
    input logic [1:0]        res_action,
    input logic              res_if,
    input logic              res_vif
);
    logic virt, strict;
    assign virt   = (iopl != '1) && vme;
    assign strict = (iopl != '1) && !vme;

    assert_pulse_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(req_valid));
    assert_req_gives_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    assert_hlt_faults_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd7) |=> (res_action == 2'd1));
    assert_io_native_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd6) |=> (res_action == 2'd0));
    assert_strict_faults_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && strict && req_op <= 3'd5) |=> (res_action == 2'd1));
    assert_virt_keeps_if_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && virt) |=> (res_if == $past(cur_if)));
    assert_vip_blocks_sti_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && virt && cur_vip && req_op == 3'd1)
        |=> (res_action == 2'd1 && res_vif == $past(cur_vif)));
    assert_redirect_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && virt && req_op == 3'd4 && redir_map[vec]) |=> (res_action == 2'd2));
endmodule

bind v86_arb v86_arb_chk #(.PRIV_W(PRIV_W), .VEC_W(VEC_W), .FLAG_W(FLAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .iopl      (iopl),
    .vme       (vme),
    .cur_if    (cur_if),
    .cur_vif   (cur_vif),
    .cur_vip   (cur_vip),
    .vec       (vec),
    .redir_map (redir_map),
    .res_valid (res_valid),
    .res_action(res_action),
    .res_if    (res_if),
    .res_vif   (res_vif)
);

// File: tb/sim_v86_arb.sv
module sim_v86_arb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [2:0]   req_op = '0;
    logic [1:0]   iopl = '0;
    logic         vme = 1'b0, cur_if = 1'b0, cur_vif = 1'b0, cur_vip = 1'b0;
    logic [7:0]   vec = '0;
    logic [255:0] redir_map = '0;
    logic [15:0]  cur_flags = '0, pop_flags = '0;
    logic         res_valid, res_if, res_vif;
    logic [1:0]   res_action;
    logic [15:0]  res_image;

    int checks = 0, fails = 0;
    logic        e_valid = 0, e_if = 0, e_vif = 0;
    int          e_act = 0;
    logic [15:0] e_img = '0;
    string       e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    v86_arb u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 valid", int'(res_valid), int'(e_valid));
        chk({e_tag, " action"}, int'(res_action), e_act);
        chk({e_tag, " if"}, int'(res_if), int'(e_if));
        chk({e_tag, " vif"}, int'(res_vif), int'(e_vif));
        chk({e_tag == "R10" ? "R10" : "R9", " image"}, int'(res_image), int'(e_img));
    endtask

    // behavioural reference: predicts the result of the request now on the inputs
    task automatic predict();
        bit trusted, virt;
        int o;
        trusted = (iopl == 2'd3);
        virt    = !trusted && vme;
        o       = int'(req_op);
        e_valid = req_valid;
        if (!req_valid) return;
        e_if = cur_if; e_vif = cur_vif; e_act = 0;
        if (o == 7) begin e_act = 1; e_tag = "R3"; end
        else if (o == 6) begin e_act = 0; e_tag = "R4"; end
        else if (!trusted && !vme) begin e_act = 1; e_tag = "R5"; end
        else if (trusted) begin
            e_tag = (o == 4) ? "R7" : "R6";
            if (o == 4) e_act = 3;
            if (o == 0) e_if = 0;
            if (o == 1) e_if = 1;
            if (o == 3) e_if = pop_flags[9];
        end else begin
            case (o)
                0: begin e_vif = 0; e_tag = "R8"; end
                1: begin
                    e_tag = cur_vip ? "R11" : "R8";
                    if (cur_vip) e_act = 1; else e_vif = 1;
                end
                2: e_tag = "R9";
                3: begin
                    e_tag = "R10";
                    if (cur_vip && pop_flags[9]) e_act = 1; else e_vif = pop_flags[9];
                end
                4: begin e_tag = "R12"; e_act = redir_map[vec] ? 2 : 1; end
                default: begin e_tag = "R13"; e_act = 1; end
            endcase
        end
        if (o == 3) begin e_img = pop_flags; e_img[9] = e_if; end
        else begin e_img = cur_flags; if (virt) e_img[9] = cur_vif; end
    endtask

    task automatic step(input bit v, input int op, input int pl, input bit ve,
                        input bit fi, input bit fv, input bit fp, input int n);
        @(negedge clk);
        compare_all();
        req_valid = v; req_op = 3'(op); iopl = 2'(pl); vme = ve;
        cur_if = fi; cur_vif = fv; cur_vip = fp; vec = 8'(n);
        cur_flags = 16'($urandom); pop_flags = 16'($urandom);
        predict();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) redir_map[i*32 +: 32] = $urandom;
        redir_map[33] = 1'b1; redir_map[34] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all(); // R1 during reset
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0, 0); // R1 first cycle after reset
        // R3, R4 across modes
        step(1, 7, 3, 1, 1, 1, 0, 0);
        step(1, 6, 0, 0, 1, 0, 0, 0);
        step(1, 6, 1, 1, 0, 1, 1, 0);
        // R5 strict
        for (int k = 0; k < 6; k++) step(1, k, 0, 0, 1, 1, 0, 5);
        // R6, R7 trusted
        for (int k = 0; k < 6; k++) step(1, k, 3, k % 2, k % 2, 1, 1, 9);
        // R8 to R13 virtual, vip interplay back to back
        step(1, 0, 2, 1, 1, 1, 0, 0);
        step(1, 1, 2, 1, 0, 0, 0, 0);
        step(1, 1, 2, 1, 1, 0, 1, 0);
        step(1, 1, 2, 1, 1, 1, 1, 0);
        step(1, 2, 1, 1, 0, 1, 0, 0);
        step(1, 3, 1, 1, 1, 0, 1, 0);
        step(1, 3, 1, 1, 0, 1, 0, 0);
        step(1, 4, 0, 1, 0, 0, 0, 33);
        step(1, 4, 0, 1, 0, 0, 0, 34);
        step(1, 5, 2, 1, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0); // R2 hold after drain
        step(0, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3000; k++)
            step(($urandom % 4) != 0, $urandom % 8, $urandom % 4, $urandom % 2,
                 $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 256);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule